// File: doc/BRIEF.md
# Flag-Gated I2C Bus Master

This block is an I2C bus master that software steps through one bus operation at a time. Software programs a bit-rate divider, loads a byte into the data register and writes a command to the control register. The command is one of START, send one byte, or STOP. Each command runs only when the write carries a one in the completion-flag position. That same one clears the flag. The block then carries out the operation on open-drain SCL and SDA. When it finishes, it writes a result code to the status register and raises the flag again.

While the flag is up the master keeps SCL low, so the bus waits for software for as long as it takes. A STOP is the one operation that ends without raising the flag. After a STOP the master goes back to idle with both lines released. Slave mode, receiving bytes and multi-master arbitration are not part of this block.

Top module: `i2c_flag_master`

## Requirements
- R1: After reset the control and status reads are 0x00 and neither SCL nor SDA is driven low.
- R2: A control write with flag (bit 7), enable (bit 0) and START (bit 1) set does the following. It pulls SDA low while SCL is high, then pulls SCL low. It then reports status 0x01, raises the flag and clears the START bit. If the previous operation left SCL low, this sequence forms a repeated START.
- R3: While the flag (control bit 7) reads one, SCL is driven low.
- R4: A control write with bit 7 set clears the flag and starts the selected command at once. A control write with bit 7 clear leaves the flag set, starts nothing and leaves both bus lines unchanged. Control, data and divider writes are ignored while an operation is running.
- R5: A send-byte command (flag and enable set, START and STOP clear) shifts out the data register most significant bit first over eight SCL pulses. A ninth pulse follows, with SDA released.
- R6: The first byte after a START reports status 0x02 when SDA is low at the end of the ninth SCL high phase (ACK), and 0x03 when it is high (NACK).
- R7: Every later byte reports 0x04 on ACK and 0x05 on NACK.
- R8: A STOP command (bit 2) pulls SDA low with SCL low, then releases SCL, then releases SDA. It ends with the flag still clear, the status at 0x00, the STOP bit cleared and both lines released.
- R9: During a byte, every SCL high phase and every SCL low phase between bits lasts divider+1 system clocks. The divider is written through register select 2.
- R10: During a byte, SDA does not change while SCL is high, so the bus sees no START or STOP conditions other than the commanded ones.
- R11: A command write with the enable bit clear starts no bus activity and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 data, 2 divider |
| wr_data | input | 8 | Write data |
| ctrl_rd | output | 8 | Control read: bit 7 flag, bit 2 STOP, bit 1 START, bit 0 enable |
| status_rd | output | 8 | Result code of the last operation |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_drive_low | output | 1 | Pull SCL low when high |
| sda_drive_low | output | 1 | Pull SDA low when high |

## Verification
The hardest state to reach is a flag that is raised while software deliberately does nothing, or while software writes the control register without the flag bit. A correct design must keep the bus frozen in that state, and a broken one does not show it unless something waits there. The bench reaches this state by attaching a behavioural slave that ACKs one address and NACKs the byte 0xFF. It then parks after each completion for several bit times, watching SCL, and at one point writes a flag-less control value. It repeats whole START/address/data/STOP transactions for every divider from 0 to 3, with both a matching and a non-matching address.

// File: rtl/i2c_fm_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the flag-gated I2C master.
// Assumes an 8-bit register interface.
package i2c_fm_pkg;
    localparam int BYTE_W = 8;

    // control register bit positions
    localparam int CTL_EN  = 0;
    localparam int CTL_STA = 1;
    localparam int CTL_STO = 2;
    localparam int CTL_FLG = 7;

    // register select values
    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_DIV  = 2'd2;

    // status codes
    localparam logic [BYTE_W-1:0] STS_IDLE  = 8'h00;
    localparam logic [BYTE_W-1:0] STS_START = 8'h01;
    localparam logic [BYTE_W-1:0] STS_AACK  = 8'h02;
    localparam logic [BYTE_W-1:0] STS_ANACK = 8'h03;
    localparam logic [BYTE_W-1:0] STS_DACK  = 8'h04;
    localparam logic [BYTE_W-1:0] STS_DNACK = 8'h05;

    typedef enum logic [1:0] {CMD_START, CMD_BYTE, CMD_STOP} cmd_e;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_HOLD,
        SQ_SSET, SQ_SRISE, SQ_SFALL, SQ_SEND,
        SQ_BLOW, SQ_BHIGH,
        SQ_PLOW, SQ_PRISE, SQ_PEND
    } seq_e;
endpackage

// File: rtl/i2c_fm_phase_timer.sv
`timescale 1ns/1ps
// Phase timer: while run is high, pulses tick once every reload+1 clocks.
// Assumes reload stays constant while run is high.
module i2c_fm_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    // count down while running, rearm at zero or when stopped
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (!run)           cnt <= reload;
        else if (cnt == '0)      cnt <= reload;
        else                     cnt <= cnt - 1'b1;
    end

    // end of the current phase
    always_comb tick = run && (cnt == '0);
endmodule

// File: rtl/i2c_fm_regs.sv
`timescale 1ns/1ps
// Register file: control (with completion flag), data, divider and status.
// Decodes command launches and applies completion results from the sequencer.
// Assumes that writes arriving while the sequencer is busy are to be dropped.
module i2c_fm_regs
    import i2c_fm_pkg::*;
#(
    parameter int                DIV_W   = 8,
    parameter logic [DIV_W-1:0]  RST_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              seq_busy,
    input  logic              op_done,
    input  logic              op_flag,
    input  logic [BYTE_W-1:0] op_code,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic [BYTE_W-1:0] status_q,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [DIV_W-1:0]  div_q,
    output logic              launch,
    output cmd_e              cmd
);
    logic flag_q, en_q, sta_q, sto_q;
    logic ctrl_wr;
    cmd_e cur_cmd;

    // decode accepted writes and the command they start
    always_comb begin
        ctrl_wr = wr_en && (wr_sel == SEL_CTRL) && !seq_busy;
        launch  = ctrl_wr && wr_data[CTL_FLG] && wr_data[CTL_EN];
        if (wr_data[CTL_STA])      cmd = CMD_START;
        else if (wr_data[CTL_STO]) cmd = CMD_STOP;
        else                       cmd = CMD_BYTE;
    end

    // control bits: software writes, flag set on completion, self-clearing START/STOP
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q  <= 1'b0;
            en_q    <= 1'b0;
            sta_q   <= 1'b0;
            sto_q   <= 1'b0;
            cur_cmd <= CMD_BYTE;
        end else if (op_done) begin
            if (op_flag)               flag_q <= 1'b1;
            if (cur_cmd == CMD_START)  sta_q  <= 1'b0;
            if (cur_cmd == CMD_STOP)   sto_q  <= 1'b0;
        end else if (ctrl_wr) begin
            en_q  <= wr_data[CTL_EN];
            sta_q <= wr_data[CTL_STA];
            sto_q <= wr_data[CTL_STO];
            if (wr_data[CTL_FLG]) flag_q <= 1'b0;
            if (launch)           cur_cmd <= cmd;
        end
    end

    // data and divider registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_byte <= '0;
            div_q   <= RST_DIV;
        end else if (wr_en && !seq_busy) begin
            if (wr_sel == SEL_DATA) tx_byte <= wr_data;
            if (wr_sel == SEL_DIV)  div_q   <= wr_data[DIV_W-1:0];
        end
    end

    // status register follows each completion
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= STS_IDLE;
        else if (op_done) status_q <= op_code;
    end

    // control read view
    always_comb begin
        ctrl_q          = '0;
        ctrl_q[CTL_FLG] = flag_q;
        ctrl_q[CTL_STO] = sto_q;
        ctrl_q[CTL_STA] = sta_q;
        ctrl_q[CTL_EN]  = en_q;
    end
endmodule

// File: rtl/i2c_fm_seq.sv
`timescale 1ns/1ps
// Bus sequencer: drives START, byte-with-ACK and STOP phases on open-drain lines.
// Each phase ends on a timer tick. Between commands it parks in HOLD (SCL low)
// or IDLE (lines released). Assumes the timer runs exactly while busy is high.
module i2c_fm_seq
    import i2c_fm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  cmd_e              cmd,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              sda_in,
    output logic              busy,
    output logic              in_byte,
    output logic              scl_low,
    output logic              sda_low,
    output logic              op_done,
    output logic              op_flag,
    output logic [BYTE_W-1:0] op_code
);
    localparam int BIT_W    = $clog2(BYTE_W + 1);
    localparam int LAST_BIT = BYTE_W;      // index of the acknowledge slot
    localparam int LAST_DAT = BYTE_W - 1;

    seq_e              st;
    logic [BYTE_W-1:0] shreg;
    logic [BIT_W-1:0]  bitcnt;
    logic              addr_next;
    logic              ack;

    // state classification and completion result
    always_comb begin
        busy    = !(st == SQ_IDLE || st == SQ_HOLD);
        in_byte = (st == SQ_BLOW) || (st == SQ_BHIGH);
        ack     = !sda_in;
        op_done = tick && ((st == SQ_SEND) || (st == SQ_PEND) ||
                           (st == SQ_BHIGH && bitcnt == BIT_W'(LAST_BIT)));
        op_flag = (st != SQ_PEND);
        case (st)
            SQ_SEND: op_code = STS_START;
            SQ_PEND: op_code = STS_IDLE;
            default: op_code = addr_next ? (ack ? STS_AACK : STS_ANACK)
                                         : (ack ? STS_DACK : STS_DNACK);
        endcase
    end

    // phase stepping and line drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_IDLE;
            scl_low   <= 1'b0;
            sda_low   <= 1'b0;
            shreg     <= '0;
            bitcnt    <= '0;
            addr_next <= 1'b0;
        end else begin
            case (st)
                SQ_IDLE, SQ_HOLD: if (launch) begin
                    case (cmd)
                        CMD_START: begin
                            st      <= SQ_SSET;
                            sda_low <= 1'b0;
                        end
                        CMD_STOP: begin
                            st      <= SQ_PLOW;
                            scl_low <= 1'b1;
                            sda_low <= 1'b1;
                        end
                        default: begin
                            st      <= SQ_BLOW;
                            scl_low <= 1'b1;
                            sda_low <= !tx_byte[BYTE_W-1];
                            shreg   <= tx_byte;
                            bitcnt  <= '0;
                        end
                    endcase
                end
                SQ_SSET:  if (tick) begin st <= SQ_SRISE; scl_low <= 1'b0; end
                SQ_SRISE: if (tick) begin st <= SQ_SFALL; sda_low <= 1'b1; end
                SQ_SFALL: if (tick) begin st <= SQ_SEND;  scl_low <= 1'b1; end
                SQ_SEND:  if (tick) begin st <= SQ_HOLD;  addr_next <= 1'b1; end
                SQ_BLOW:  if (tick) begin st <= SQ_BHIGH; scl_low <= 1'b0; end
                SQ_BHIGH: if (tick) begin
                    scl_low <= 1'b1;
                    if (bitcnt == BIT_W'(LAST_BIT)) begin
                        st        <= SQ_HOLD;
                        sda_low   <= 1'b0;
                        addr_next <= 1'b0;
                    end else begin
                        st      <= SQ_BLOW;
                        bitcnt  <= bitcnt + 1'b1;
                        shreg   <= shreg << 1;
                        sda_low <= (bitcnt == BIT_W'(LAST_DAT)) ? 1'b0 : !shreg[BYTE_W-2];
                    end
                end
                SQ_PLOW:  if (tick) begin st <= SQ_PRISE; scl_low <= 1'b0; end
                SQ_PRISE: if (tick) begin st <= SQ_PEND;  sda_low <= 1'b0; end
                SQ_PEND:  if (tick) begin st <= SQ_IDLE;  addr_next <= 1'b0; end
                default:  st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_flag_master.sv
`timescale 1ns/1ps
// Top: software-stepped I2C master. Register file, phase timer and bus sequencer.
// Assumes external pull-ups on SCL/SDA and a slave that does not stretch SCL.
module i2c_flag_master
    import i2c_fm_pkg::*;
#(
    parameter int               DIV_W   = 8,
    parameter logic [DIV_W-1:0] RST_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [7:0]  wr_data,
    output logic [7:0]  ctrl_rd,
    output logic [7:0]  status_rd,
    input  logic        sda_in,
    output logic        scl_drive_low,
    output logic        sda_drive_low
);
    logic              seq_busy, seq_in_byte, launch, tick;
    logic              op_done, op_flag;
    logic [BYTE_W-1:0] op_code, tx_byte;
    logic [DIV_W-1:0]  div_q;
    cmd_e              cmd;

    i2c_fm_regs #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .seq_busy(seq_busy), .op_done(op_done), .op_flag(op_flag), .op_code(op_code),
        .ctrl_q(ctrl_rd), .status_q(status_rd), .tx_byte(tx_byte), .div_q(div_q),
        .launch(launch), .cmd(cmd)
    );

    i2c_fm_phase_timer #(.CNT_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(seq_busy), .reload(div_q), .tick(tick)
    );

    i2c_fm_seq u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .cmd(cmd), .tx_byte(tx_byte),
        .tick(tick), .sda_in(sda_in), .busy(seq_busy), .in_byte(seq_in_byte),
        .scl_low(scl_drive_low), .sda_low(sda_drive_low),
        .op_done(op_done), .op_flag(op_flag), .op_code(op_code)
    );
endmodule

// File: rtl/i2c_flag_master_chk.sv
`timescale 1ns/1ps
// Property checker for i2c_flag_master, attached by bind below.
module i2c_flag_master_chk
    import i2c_fm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic [7:0] wr_data,
    input logic [7:0] ctrl_rd,
    input logic [7:0] status_rd,
    input logic       scl_drive_low,
    input logic       sda_drive_low,
    input logic       op_done,
    input logic       op_flag,
    input logic [7:0] op_code,
    input logic       seq_in_byte
);
    // raised flag means SCL is held low
    p_flag_holds_scl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[CTL_FLG] |-> scl_drive_low);

    // without a flag-clearing write the bus stays frozen
    p_flag_blocks_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd[CTL_FLG] && !(wr_en && wr_sel == SEL_CTRL && wr_data[CTL_FLG]))
        |=> (ctrl_rd[CTL_FLG] && $stable(scl_drive_low) && $stable(sda_drive_low)));

    // START completion clears the START bit
    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_code == STS_START) |=> (!ctrl_rd[CTL_STA] && ctrl_rd[CTL_FLG]));

    // flagged completions leave a non-idle status
    p_done_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && op_flag) |=> (ctrl_rd[CTL_FLG] && status_rd != STS_IDLE));

    // STOP completion: no flag, idle status, released lines
    p_stop_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !op_flag) |=> (!ctrl_rd[CTL_FLG] && status_rd == STS_IDLE &&
                                   !scl_drive_low && !sda_drive_low && !ctrl_rd[CTL_STO]));

    // SDA steady across an SCL high phase within a byte
    p_sda_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_in_byte && !scl_drive_low && $past(!scl_drive_low)) |-> $stable(sda_drive_low));
endmodule

bind i2c_flag_master i2c_flag_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .status_rd(status_rd), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low), .op_done(op_done), .op_flag(op_flag),
    .op_code(op_code), .seq_in_byte(seq_in_byte)
);

// File: tb/sim_i2c_flag_master.sv
`timescale 1ns/1ps
module sim_i2c_flag_master;
    localparam logic [6:0] SLV_ADDR = 7'h2C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ctrl_rd, status_rd;
    logic       scl_drive_low, sda_drive_low;
    logic       slave_low = 1'b0;
    logic       scl_bus, sda_bus;

    assign scl_bus = !scl_drive_low;
    assign sda_bus = !(sda_drive_low || slave_low);

    i2c_flag_master u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ctrl_rd(ctrl_rd), .status_rd(status_rd), .sda_in(sda_bus),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
    );

    always #10 clk = ~clk;

    int nchk = 0, nerr = 0;
    bit done_flag = 1'b0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- behavioural slave and bus monitor ----------------
    logic       p_scl = 1'b1, p_sda = 1'b1;
    int         bitpos = 0, nstart = 0, nstop = 0;
    bit         first_byte = 1'b0, addressed = 1'b0;
    logic [7:0] sh = 8'h00, last_rx = 8'h00;
    int         t_rise = 0, t_fall = 0, cur_div = 4, hi_bad = 0, lo_bad = 0;

    always @(negedge clk) begin
        if (p_scl && scl_bus && p_sda && !sda_bus) begin
            nstart++; bitpos = 0; first_byte = 1'b1;
        end
        if (p_scl && scl_bus && !p_sda && sda_bus) begin
            nstop++; bitpos = 0; addressed = 1'b0;
        end
        if (!p_scl && scl_bus) begin
            if (bitpos >= 1 && (cyc - t_fall) != cur_div + 1) lo_bad++;
            t_rise = cyc;
            if (bitpos < 8) sh = {sh[6:0], sda_bus};
            bitpos++;
        end
        if (p_scl && !scl_bus) begin
            if (bitpos >= 1 && (cyc - t_rise) != cur_div + 1) hi_bad++;
            t_fall = cyc;
            if (bitpos == 8) begin
                last_rx = sh;
                if (first_byte) begin
                    addressed  = (sh[7:1] == SLV_ADDR);
                    first_byte = 1'b0;
                    slave_low  = addressed;
                end else begin
                    slave_low = addressed && (sh != 8'hFF);
                end
            end else if (bitpos == 9) begin
                slave_low = 1'b0;
                bitpos = 0;
            end
        end
        p_scl = scl_bus;
        p_sda = sda_bus;
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_flag(input string req);
        int n = 0;
        while (!ctrl_rd[7] && n < 3000) begin
            @(negedge clk); n++;
        end
        check(ctrl_rd[7] == 1'b1, req, ctrl_rd, 8'h80);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic [7:0] exp, input string req);
        wr(2'd1, b);
        wr(2'd0, 8'h81);
        wait_flag(req);
        check(status_rd == exp, req, status_rd, exp);
        check(last_rx == b, "R5 byte MSB-first", last_rx, b);   // R5
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int exp_start = 0, exp_stop = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ctrl_rd == 8'h00, "R1 ctrl", ctrl_rd, 0);
        check(status_rd == 8'h00, "R1 status", status_rd, 0);
        check(!scl_drive_low && !sda_drive_low, "R1 lines", {scl_drive_low, sda_drive_low}, 0);

        // R11 disabled command does nothing
        wr(2'd0, 8'h82);
        repeat (40) @(negedge clk);
        check(nstart == 0, "R11 no START", nstart, 0);
        check(status_rd == 8'h00 && !scl_drive_low, "R11 idle", status_rd, 0);

        for (int dv = 0; dv < 4; dv++) begin
            for (int k = 0; k < 2; k++) begin
                bit         match = (k == 0);
                logic [6:0] a = match ? SLV_ADDR : SLV_ADDR ^ 7'h11;
                int         bad = 0;
                cur_div = dv;
                wr(2'd2, 8'(dv));
                // R2 START
                wr(2'd0, 8'h83);
                wait_flag("R2 START flag");
                exp_start++;
                check(status_rd == 8'h01, "R2 START status", status_rd, 1);
                check(ctrl_rd[1] == 1'b0, "R2 START self-clear", ctrl_rd, 8'h81);
                check(nstart == exp_start, "R2 START seen", nstart, exp_start);
                // R3 SCL held while flag up
                for (int c = 0; c < 3 * (dv + 2) + 8; c++) begin
                    @(negedge clk);
                    if (!scl_drive_low || !ctrl_rd[7]) bad++;
                end
                check(bad == 0, "R3 SCL held", bad, 0);
                // R4 write without flag bit changes nothing
                if (k == 0) begin
                    wr(2'd0, 8'h01);
                    repeat (4 * (dv + 1) + 6) @(negedge clk);
                    check(ctrl_rd[7] && scl_drive_low && sda_drive_low && status_rd == 8'h01,
                          "R4 flag kept", {ctrl_rd[7], scl_drive_low, sda_drive_low}, 3'b111);
                end
                // R6 address byte
                send_byte({a, 1'b0}, match ? 8'h02 : 8'h03, "R6 address status");
                if (match) begin
                    // R7 data bytes
                    send_byte(8'hA5, 8'h04, "R7 data ACK");
                    send_byte(8'hFF, 8'h05, "R7 data NACK");
                    // R2 repeated START from a held bus
                    wr(2'd0, 8'h83);
                    wait_flag("R2 repeated START flag");
                    exp_start++;
                    check(nstart == exp_start, "R2 repeated START seen", nstart, exp_start);
                    send_byte({a, 1'b0}, 8'h02, "R6 address after repeated START");
                end
                // R8 STOP
                wr(2'd0, 8'h85);
                repeat (4 * (dv + 1) + 10) @(negedge clk);
                exp_stop++;
                check(!ctrl_rd[7], "R8 no flag", ctrl_rd, 0);
                check(status_rd == 8'h00 && ctrl_rd[2] == 1'b0, "R8 status/stop bit", status_rd, 0);
                check(!scl_drive_low && !sda_drive_low, "R8 lines released",
                      {scl_drive_low, sda_drive_low}, 0);
                check(nstop == exp_stop, "R8 STOP seen", nstop, exp_stop);
            end
        end
        check(hi_bad == 0, "R9 high phase", hi_bad, 0);
        check(lo_bad == 0, "R9 low phase", lo_bad, 0);
        check(nstart == exp_start && nstop == exp_stop, "R10 no stray conditions",
              nstart + nstop, exp_start + exp_stop);
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule